// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block places one 8-bit companded voice sample per frame on a single serial line that several transmitters share. It runs on a fast system clock. It samples the bit clock, the frame sync and the power-down line through synchronizer flops and finds their rising edges inside the block. A rising edge of the frame sync opens an 8-bit slot. The most significant bit goes out at once. Each later rising edge of the bit clock moves to the next bit, and the rising edge after the last bit closes the slot.

While a slot is open the block asserts an output-enable for an open-drain or tri-state pad. At all other times the enable is low, so the pulled-up line rests high. A law-select input picks one of two line codings. In mu-law mode the sample goes out unchanged. In A-law mode every second bit is flipped. An active-low power-down input keeps the line released and cuts off any slot in progress.

Top module: `pcm_tx_port`

## Requirements
- R1: While reset is asserted and directly after it, `pcm_oe` is 0 and `pcm_out` is 1.
- R2: A slot carries exactly 8 bits, most significant first. Between accepted bit-clock rising edges, `pcm_out` and `pcm_oe` hold their values.
- R3: When the block is idle and powered up, a frame-sync rising edge opens a slot and drives the most significant bit at once. This holds whether the sync rises together with a bit-clock rising edge or between two of them. A bit-clock edge that coincides with the opening sync edge does not advance the slot.
- R4: Outside a slot, `pcm_oe` is 0 and `pcm_out` is 1. The slot closes on the 8th bit-clock rising edge after it opened.
- R5: While `pdn_n` is 0, `pcm_oe` stays 0 and no slot opens. A slot in progress when `pdn_n` falls is cut off.
- R6: After `pdn_n` returns to 1, nothing is driven until a new frame-sync rising edge. A sync that was already high when power returned does not open a slot.
- R7: With `alaw_sel` = 0 the sample bits go out unchanged (e.g. 8'h80, 8'hFF, 8'h7F, 8'h00 are sent as such).
- R8: With `alaw_sel` = 1 the sent byte is the sample XOR 8'h55, which flips bits 2, 4, 6 and 8 counting the MSB as bit 1. Inputs 8'hFF, 8'h80, 8'h00 and 8'h7F therefore go out as 8'hAA, 8'hD5, 8'h55 and 8'h2A.
- R9: The sample and law select are captured when the slot opens. Changing `sample` during a slot does not change the bits sent.
- R10: A frame-sync rising edge during an open slot is ignored, and the slot still ends after exactly 8 bits.
- R11: An edge on `bclk`, `fsync` or `pdn_n` takes effect on `pcm_out`/`pcm_oe` at the third `clk` rising edge after the change, with SYNC_STAGES = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock (asynchronous, sampled) |
| fsync | input | 1 | Frame sync; a rising edge opens a slot |
| pdn_n | input | 1 | Active-low power-down |
| alaw_sel | input | 1 | 1 = A-law alternate-bit inversion, 0 = mu-law (unchanged) |
| sample | input | 8 | Companded sample to send |
| pcm_out | output | 1 | Serial data; 1 when not enabled |
| pcm_oe | output | 1 | Pad output-enable, high only during the 8-bit slot |

## Verification
On every cycle, the bound checker confirms four things. Power-down releases the line. An idle, powered block opens a slot only on a sync edge. The data and enable hold between bit-clock edges, even when a stray sync edge arrives. A slot never outlives 8 bit-clock edges. Only the bench scenarios can show that the serialized bytes are the right values in both laws, and that both sync alignments give the full frame. They also show that a sample changed mid-slot is not sent, and that a sync already high at power-up is ignored.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    // Slot state of the serializer
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SLOT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/pcm_tx_sync.sv
// Multi-bit flop-chain synchronizer; STAGES = 0 selects a pass-through.
module pcm_tx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_sync = d_async;
        end else begin : g_chain
            logic [WIDTH-1:0] stg_q [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q <= '{default: '0};
                end else begin
                    stg_q[0] <= d_async;
                    for (int i = 1; i < STAGES; i++) begin
                        stg_q[i] <= stg_q[i-1];
                    end
                end
            end
            assign q_sync = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pcm_tx_edge.sv
// Rising-edge detector on synchronized levels.
module pcm_tx_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/pcm_tx_coder.sv
// Line coding: alternate-bit inversion (even positions counted from the LSB) in A-law mode.
module pcm_tx_coder #(
    parameter int W = 8
) (
    input  logic         alaw,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i % 2 == 0) begin : g_inv
                assign dout[i] = din[i] ^ alaw;
            end else begin : g_pass
                assign dout[i] = din[i];
            end
        end
    endgenerate
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                fsync,
    input  logic                pdn_n,
    input  logic                alaw_sel,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                pcm_out,
    output logic                pcm_oe
);
    localparam int CNT_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLE_W - 1);

    typedef struct packed {
        tx_state_e            st;
        logic [CNT_W-1:0]     idx;
        logic [SAMPLE_W-1:0]  sh;
    } tx_regs_t;

    logic [2:0]          lvl_s;
    logic [1:0]          rise;
    logic                pdn_s;
    logic                fs_rise;
    logic                bc_rise;
    logic [SAMPLE_W-1:0] coded;
    tx_regs_t            tx_d, tx_q;

    // {power-down, frame sync, bit clock} through the synchronizer
    pcm_tx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pdn_n, fsync, bclk}),
        .q_sync  (lvl_s)
    );

    pcm_tx_edge #(.WIDTH(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl_s[1:0]),
        .rise  (rise)
    );

    pcm_tx_coder #(.W(SAMPLE_W)) u_coder (
        .alaw (alaw_sel),
        .din  (sample),
        .dout (coded)
    );

    assign pdn_s   = lvl_s[2];
    assign fs_rise = rise[1];
    assign bc_rise = rise[0];

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q.st)
            ST_IDLE: begin
                if (fs_rise) begin
                    tx_d.st  = ST_SLOT;
                    tx_d.idx = '0;
                    tx_d.sh  = coded;
                end
            end
            ST_SLOT: begin
                if (bc_rise) begin
                    if (tx_q.idx == LAST_IDX) begin
                        tx_d.st = ST_IDLE;
                    end else begin
                        tx_d.idx = tx_q.idx + CNT_W'(1);
                        tx_d.sh  = {tx_q.sh[SAMPLE_W-2:0], 1'b0};
                    end
                end
            end
            default: tx_d.st = ST_IDLE;
        endcase
        if (!pdn_s) begin
            tx_d.st  = ST_IDLE;
            tx_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q.st  <= ST_IDLE;
            tx_q.idx <= '0;
            tx_q.sh  <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign pcm_oe  = (tx_q.st == ST_SLOT);
    assign pcm_out = pcm_oe ? tx_q.sh[SAMPLE_W-1] : 1'b1;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk #(
    parameter int SAMPLE_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic pdn_s,
    input logic fs_rise,
    input logic bc_rise,
    input logic pcm_out,
    input logic pcm_oe
);
    localparam int ACW = $clog2(SAMPLE_W + 1);
    logic [ACW-1:0] adv_cnt;

    // counts accepted bit-clock edges inside the current slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       adv_cnt <= '0;
        else if (!pcm_oe) adv_cnt <= '0;
        else if (bc_rise) adv_cnt <= adv_cnt + ACW'(1);
    end

    assert_pdn_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_s |=> !pcm_oe);

    assert_open_on_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_s && !pcm_oe && fs_rise) |=> pcm_oe);

    assert_hold_between_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_s && pcm_oe && !bc_rise) |=> (pcm_oe && $stable(pcm_out)));

    assert_wait_for_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pcm_oe && !fs_rise) |=> !pcm_oe);

    assert_slot_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_oe |-> (adv_cnt < ACW'(SAMPLE_W)));

    assert_sync_in_slot_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_s && pcm_oe && fs_rise && !bc_rise) |=> (pcm_oe && $stable(pcm_out)));
endmodule

bind pcm_tx_port pcm_tx_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pdn_s   (pdn_s),
    .fs_rise (fs_rise),
    .bc_rise (bc_rise),
    .pcm_out (pcm_out),
    .pcm_oe  (pcm_oe)
);

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb;
    localparam int SYNC = 2;
    localparam int H    = 6;   // bit-clock half period in clk cycles

    logic       clk = 0, rst_n = 0, bclk = 0, fsync = 0, pdn_n = 1, alaw_sel = 0;
    logic [7:0] sample = 8'h00;
    logic       pcm_out, pcm_oe;
    int         checks = 0, errors = 0;
    bit         chk_en = 0;
    string      cur_req = "R11";

    always #2 clk = ~clk;   // 250 MHz

    pcm_tx_port #(.SAMPLE_W(8), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .pdn_n(pdn_n),
        .alaw_sel(alaw_sel), .sample(sample), .pcm_out(pcm_out), .pcm_oe(pcm_oe)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct { bit oe; bit d; } exp_t;
    exp_t       expq[$];
    exp_t       exp_now;
    bit         m_act, m_pb, m_pf;
    int         m_idx;
    logic [7:0] m_sh;

    always @(posedge clk) begin
        exp_t cur;
        bit   br, fr;
        if (!rst_n) begin
            m_act = 0; m_idx = 0; m_pb = 0; m_pf = 0; m_sh = 0;
            expq.delete();
            for (int i = 0; i < SYNC; i++) expq.push_back('{oe: 0, d: 1});
            exp_now = '{oe: 0, d: 1};
        end else begin
            br = bclk && !m_pb;
            fr = fsync && !m_pf;
            if (!pdn_n) m_act = 0;
            else if (m_act) begin
                if (br) begin
                    if (m_idx == 7) m_act = 0;
                    else begin m_idx++; m_sh = {m_sh[6:0], 1'b0}; end
                end
            end else if (fr) begin
                m_act = 1; m_idx = 0;
                m_sh = alaw_sel ? (sample ^ 8'h55) : sample;
            end
            m_pb = bclk; m_pf = fsync;
            cur.oe = m_act;
            cur.d  = m_act ? m_sh[7] : 1'b1;
            expq.push_back(cur);
            exp_now = expq.pop_front();
        end
    end

    // per-cycle comparison, R11 latency and R4 idle level included
    always @(negedge clk) begin
        if (chk_en) begin
            checks++;
            if (pcm_oe !== exp_now.oe || pcm_out !== exp_now.d) begin
                errors++;
                $display("FAIL %s/R11 per-cycle: oe=%0b out=%0b expected oe=%0b out=%0b at %0t",
                         cur_req, pcm_oe, pcm_out, exp_now.oe, exp_now.d, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // mode: 0 plain, 1 sample change mid-slot, 2 extra sync mid-slot, 3 power-down mid-slot
    task automatic frame(input logic [7:0] smp, input bit law, input bit between,
                         input int mode, input logic [7:0] alt,
                         output logic [7:0] got, output int nb);
        sample = smp; alaw_sel = law;
        got = 0; nb = 0;
        for (int p = 0; p < 10; p++) begin
            bclk = 1;
            if (p == 0 && !between) fsync = 1;
            if (mode == 2 && p == 4) fsync = 1;
            tick(1);
            if (p == 0 && between) fsync = 1;
            if (mode == 1 && p == 3) sample = alt;
            if (mode == 3 && p == 3) pdn_n = 0;
            tick(H - 1);
            if (pcm_oe) begin got = {got[6:0], pcm_out}; nb++; end
            bclk = 0;
            if (p == 2 || (mode == 2 && p == 5)) fsync = 0;
            tick(H);
        end
        tick(4);
    endtask

    task automatic bclk_only(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            bclk = 1; tick(H);
            if (pcm_oe) seen++;
            bclk = 0; tick(H);
        end
    endtask

    task automatic std_frame(input logic [7:0] smp, input bit law, input bit between,
                             input logic [7:0] exp, input string req);
        logic [7:0] got;
        int nb;
        cur_req = req;
        frame(smp, law, between, 0, 8'h00, got, nb);
        chk(nb == 8, req, "bit count", nb, 8);
        chk(got == exp, req, "frame", got, exp);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] got;
        int nb, seen, lat;
        tick(2);
        chk(pcm_oe == 0 && pcm_out == 1, "R1", "oe/out in reset", {pcm_oe, pcm_out}, 2'b01);
        tick(1); rst_n = 1;
        tick(1);
        chk(pcm_oe == 0 && pcm_out == 1, "R1", "oe/out after reset", {pcm_oe, pcm_out}, 2'b01);
        tick(3); chk_en = 1;

        // R7 mu-law, sync aligned with bit clock (R3, R2)
        std_frame(8'h80, 0, 0, 8'h80, "R7");
        std_frame(8'hFF, 0, 1, 8'hFF, "R7");
        std_frame(8'h7F, 0, 0, 8'h7F, "R7");
        std_frame(8'h00, 0, 1, 8'h00, "R7");
        // R8 A-law, both alignments (R3)
        std_frame(8'hFF, 1, 1, 8'hAA, "R8");
        std_frame(8'h80, 1, 0, 8'hD5, "R8");
        std_frame(8'h00, 1, 1, 8'h55, "R8");
        std_frame(8'h7F, 1, 0, 8'h2A, "R8");
        std_frame(8'hC3, 0, 1, 8'hC3, "R2");
        chk(pcm_oe == 0 && pcm_out == 1, "R4", "idle after slot", {pcm_oe, pcm_out}, 2'b01);

        // R9: sample changes mid-slot
        cur_req = "R9";
        frame(8'hB4, 0, 0, 1, 8'h4B, got, nb);
        chk(nb == 8 && got == 8'hB4, "R9", "frame after mid-slot sample change", got, 8'hB4);

        // R10: extra sync inside slot
        cur_req = "R10";
        frame(8'h96, 1, 1, 2, 8'h00, got, nb);
        chk(nb == 8, "R10", "bit count with extra sync", nb, 8);
        chk(got == (8'h96 ^ 8'h55), "R10", "frame with extra sync", got, 8'h96 ^ 8'h55);

        // R11: launch latency in clk cycles
        cur_req = "R11";
        sample = 8'hE1; alaw_sel = 0;
        bclk = 1; fsync = 1; lat = 0;
        while (!pcm_oe && lat < 10) begin tick(1); lat++; end
        chk(lat == SYNC + 1, "R11", "launch latency", lat, SYNC + 1);
        tick(H - lat); bclk = 0; fsync = 0; tick(H);
        bclk_only(8, seen);
        chk(seen == 7, "R4", "slot open count over 8 edges", seen, 7);
        chk(pcm_oe == 0, "R4", "oe after 8th edge", pcm_oe, 0);
        tick(4);

        // R5: power-down cuts off a slot, then blocks new slots
        cur_req = "R5";
        frame(8'hA5, 0, 0, 3, 8'h00, got, nb);
        chk(nb == 3, "R5", "bits before power-down", nb, 3);
        chk(got[2:0] == 3'b101, "R5", "bits before power-down value", got[2:0], 3'b101);
        frame(8'h3C, 0, 0, 0, 8'h00, got, nb);
        chk(nb == 0, "R5", "bits sent while powered down", nb, 0);

        // R6: sync already high at power-up is not a start
        cur_req = "R6";
        fsync = 1; tick(5);
        pdn_n = 1; tick(6);
        bclk_only(3, seen);
        chk(seen == 0 && pcm_oe == 0, "R6", "drive without new sync", seen, 0);
        fsync = 0; tick(4);
        std_frame(8'h5A, 1, 0, 8'h0F, "R6");

        tick(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule